// File: doc/BRIEF.md
# Ring Scatter Forwarding Node

This block is the per-node engine of a pipelined scatter on a one-way ring of `p` nodes. A root node `k` holds one message for every node of the ring. It streams the messages to its successor, farthest destination first, and then keeps its own entry. Every other node takes words from its predecessor, passes a computed number of them on, and keeps the one that follows.

Each node knows its own position `q` through the parameter `NODE_IDX`. A `start` pulse samples the root index and the ring size. The number of words to pass on is `(k-1-q) mod p`, worked out from those sampled values. Words enter and leave through valid/ready ports. Two storage slots swap roles after each arrival, so one word can be sent while the next one is being received.

The controller has five states:
- `ST_IDLE` waits after reset.
- `ST_SETUP` spends one cycle on the modular arithmetic and, at the root, loads the first outbound word.
- `ST_ROOT_TX` streams the root's words.
- `ST_RELAY` receives, passes on and keeps words at a non-root node.
- `ST_DONE` holds the result.

The transitions are:
- `start` in `ST_IDLE` or `ST_DONE` goes to `ST_SETUP`.
- `ST_SETUP` goes to `ST_ROOT_TX` when `q == k`, and to `ST_RELAY` otherwise.
- `ST_ROOT_TX` goes to `ST_DONE` on the accepted last send.
- `ST_RELAY` goes to `ST_DONE` once the kept word is stored and both slots are empty.

Top module: `ring_scatter_node`

## Requirements
- R1: After reset, `tx_valid`, `rx_ready` and `done` are all low.
- R2: At the root, the i-th accepted send (i = 1 .. p-1) carries table entry `(k+p-i) mod p`. Entry j sits at bits `[j*DATA_W +: DATA_W]` of `msg_tbl`. The root makes exactly p-1 sends.
- R3: After its last send, the root presents table entry k on `own_msg` and raises `done`.
- R4: A non-root node passes on exactly `(k-1-q) mod p` arrivals, unchanged and in arrival order.
- R5: At a non-root node, arrival number `((k-1-q) mod p)+1` appears on `own_msg`. After that arrival `rx_ready` stays low, and no further word is accepted.
- R6: The node just upstream of the root (`q == (k-1) mod p`) passes nothing on and keeps its first arrival.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R8: A word waiting to be sent is never overwritten. With the output stalled, at most two words are accepted: one in each slot.
- R9: With `tx_ready` held high and words offered every cycle, a relaying node accepts one word per cycle from its first arrival until it keeps a word.
- R10: `done` rises only when the kept word is stored and nothing waits to be sent. It stays high with `tx_valid` and `rx_ready` low until the next `start`. A `start` while busy is ignored.
- R11: The root never raises `rx_ready`.
- R12: A `start` in `ST_DONE` begins a new scatter with newly sampled `root_idx` and `ring_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a scatter; sampled in idle or done |
| root_idx | input | IW | Root node index k, sampled on start |
| ring_size | input | CW | Node count p (2 .. MAX_NODES), sampled on start |
| msg_tbl | input | MAX_NODES*DATA_W | Root message table, entry j at bits j*DATA_W |
| rx_valid | input | 1 | Word offered by the predecessor |
| rx_data | input | DATA_W | Offered word |
| rx_ready | output | 1 | Node accepts a word this cycle |
| tx_valid | output | 1 | Word offered to the successor |
| tx_data | output | DATA_W | Outgoing word |
| tx_ready | input | 1 | Successor accepts the word |
| own_msg | output | DATA_W | The node's kept message |
| done | output | 1 | Scatter complete at this node |

## Verification
Most internal faults show up within a cycle or two as a wrong word on `tx_data` or `own_msg`. A wrong forward budget shows up at the ports in three ways: an extra or a missing send, a kept word one position off, or `rx_ready` staying high after the kept arrival. A slot swap at the wrong moment changes `tx_data` during a stall on the next clock, or repeats and drops words in the outgoing stream. A faulty stall path lets a third word in while the output is blocked. The bench models the expected stream, the kept word and the stall rules from the requirements. Every cycle it checks output stability and the acceptance limits.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROOT_TX,
        ST_RELAY,
        ST_DONE
    } rs_state_e;
endpackage

// File: rtl/rs_ring_math.sv
// Modular arithmetic on the sampled root index and ring size.
module rs_ring_math #(
    parameter int MAX_NODES = 8,
    parameter int NODE_IDX  = 0,
    localparam int IW = $clog2(MAX_NODES),
    localparam int CW = $clog2(MAX_NODES + 1)
) (
    input  logic [IW-1:0] k_idx,
    input  logic [CW-1:0] p_cnt,
    output logic          is_root,
    output logic [CW-1:0] fwd_cnt,
    output logic [IW-1:0] first_dest
);
    localparam int QI = NODE_IDX;

    int kk;
    int pp;
    int ff;

    always_comb begin
        kk = int'(k_idx);
        pp = int'(p_cnt);
        if (QI < kk) begin
            ff = kk - 1 - QI;
        end else begin
            ff = kk + pp - 1 - QI;
        end
        if (ff < 0) begin
            ff = 0;
        end
        fwd_cnt    = CW'(ff);
        is_root    = (k_idx == IW'(QI));
        first_dest = (k_idx == '0) ? IW'(p_cnt - CW'(1)) : (k_idx - IW'(1));
    end
endmodule

// File: rtl/rs_dest_walk.sv
// Root destination pointer: moves one step downward around the ring on each send.
module rs_dest_walk #(
    parameter int MAX_NODES = 8,
    localparam int IW = $clog2(MAX_NODES),
    localparam int CW = $clog2(MAX_NODES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] first,
    input  logic          step,
    input  logic [CW-1:0] p_cnt,
    output logic [IW-1:0] cur,
    output logic [IW-1:0] nxt
);
    always_comb begin
        nxt = (cur == '0) ? IW'(p_cnt - CW'(1)) : (cur - IW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= first;
        end else if (step) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/rs_pingpong.sv
// Two slots: one receives while the other sends; their roles swap after a forwarded arrival.
module rs_pingpong #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              root_load,
    input  logic [DATA_W-1:0] root_word,
    input  logic              root_drop,
    input  logic              rx_store,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              tx_fire,
    output logic              tx_vld,
    output logic [DATA_W-1:0] tx_word,
    output logic              rx_full
);
    logic [DATA_W-1:0] bank [2];
    logic              sel;
    logic              tx_free;

    always_comb begin
        tx_free = !tx_vld || tx_fire;
        tx_word = bank[~sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= 1'b0;
            rx_full <= 1'b0;
            tx_vld  <= 1'b0;
        end else if (clr) begin
            rx_full <= 1'b0;
            tx_vld  <= 1'b0;
        end else if (root_load) begin
            tx_vld <= 1'b1;
        end else if (root_drop) begin
            tx_vld <= 1'b0;
        end else if (rx_store) begin
            if (tx_free) begin
                sel    <= ~sel;
                tx_vld <= 1'b1;
            end else begin
                rx_full <= 1'b1;
            end
        end else if (rx_full && tx_free) begin
            sel     <= ~sel;
            tx_vld  <= 1'b1;
            rx_full <= 1'b0;
        end else if (tx_fire) begin
            tx_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (root_load) begin
            bank[~sel] <= root_word;
        end else if (rx_store) begin
            bank[sel] <= rx_word;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && !tx_fire) |=> (tx_vld && $stable(tx_word))); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> !rx_full); // R8
endmodule

// File: rtl/ring_scatter_node.sv
module ring_scatter_node #(
    parameter int MAX_NODES = 8,
    parameter int DATA_W    = 16,
    parameter int NODE_IDX  = 0,
    localparam int IW = $clog2(MAX_NODES),
    localparam int CW = $clog2(MAX_NODES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [IW-1:0]               root_idx,
    input  logic [CW-1:0]               ring_size,
    input  logic [MAX_NODES*DATA_W-1:0] msg_tbl,
    input  logic                        rx_valid,
    input  logic [DATA_W-1:0]           rx_data,
    output logic                        rx_ready,
    output logic                        tx_valid,
    output logic [DATA_W-1:0]           tx_data,
    input  logic                        tx_ready,
    output logic [DATA_W-1:0]           own_msg,
    output logic                        done
);
    import rs_pkg::*;

    rs_state_e state, state_nx;

    logic [IW-1:0]     k_r;
    logic [CW-1:0]     p_r;
    logic [CW-1:0]     fwd_r;
    logic [CW-1:0]     sent_i;
    logic [CW-1:0]     rcnt;
    logic [CW-1:0]     relay_sent;
    logic              kept;
    logic [DATA_W-1:0] own_r;

    logic              is_root;
    logic [CW-1:0]     fwd_cnt;
    logic [IW-1:0]     first_dest;
    logic [IW-1:0]     walk_cur;
    logic [IW-1:0]     walk_nxt;

    logic              accept_start;
    logic              rx_fire;
    logic              tx_fire;
    logic              rx_store;
    logic              keep_now;
    logic              last_send;
    logic              root_load;
    logic              root_drop;
    logic [IW-1:0]     word_idx;
    logic [DATA_W-1:0] root_word;
    logic              rx_full;

    rs_ring_math #(.MAX_NODES(MAX_NODES), .NODE_IDX(NODE_IDX)) u_math (
        .k_idx      (k_r),
        .p_cnt      (p_r),
        .is_root    (is_root),
        .fwd_cnt    (fwd_cnt),
        .first_dest (first_dest)
    );

    rs_dest_walk #(.MAX_NODES(MAX_NODES)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_SETUP),
        .first (first_dest),
        .step  (root_load && (state == ST_ROOT_TX)),
        .p_cnt (p_r),
        .cur   (walk_cur),
        .nxt   (walk_nxt)
    );

    rs_pingpong #(.DATA_W(DATA_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept_start),
        .root_load (root_load),
        .root_word (root_word),
        .root_drop (root_drop),
        .rx_store  (rx_store),
        .rx_word   (rx_data),
        .tx_fire   (tx_fire),
        .tx_vld    (tx_valid),
        .tx_word   (tx_data),
        .rx_full   (rx_full)
    );

    // Output and strobe decode
    always_comb begin
        accept_start = start && ((state == ST_IDLE) || (state == ST_DONE));
        rx_ready     = (state == ST_RELAY) && !rx_full && !kept;
        rx_fire      = rx_valid && rx_ready;
        tx_fire      = tx_valid && tx_ready;
        rx_store     = rx_fire && (rcnt < fwd_r);
        keep_now     = rx_fire && (rcnt == fwd_r);
        last_send    = (sent_i == (p_r - CW'(1)));
        root_load    = ((state == ST_SETUP) && is_root) ||
                       ((state == ST_ROOT_TX) && tx_fire && !last_send);
        root_drop    = (state == ST_ROOT_TX) && tx_fire && last_send;
        word_idx     = (state == ST_SETUP) ? first_dest : walk_nxt;
        root_word    = msg_tbl[int'(word_idx)*DATA_W +: DATA_W];
        own_msg      = own_r;
        done         = (state == ST_DONE);
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = is_root ? ST_ROOT_TX : ST_RELAY;
            ST_ROOT_TX: if (root_drop) state_nx = ST_DONE;
            ST_RELAY:   if (kept && !tx_valid && !rx_full) state_nx = ST_DONE;
            ST_DONE:    if (start) state_nx = ST_SETUP;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_r        <= '0;
            p_r        <= CW'(2);
            fwd_r      <= '0;
            sent_i     <= '0;
            rcnt       <= '0;
            relay_sent <= '0;
            kept       <= 1'b0;
            own_r      <= '0;
        end else begin
            if (accept_start) begin
                k_r <= root_idx;
                p_r <= ring_size;
            end
            if (state == ST_SETUP) begin
                fwd_r      <= fwd_cnt;
                sent_i     <= CW'(1);
                rcnt       <= '0;
                relay_sent <= '0;
                kept       <= 1'b0;
            end
            if ((state == ST_ROOT_TX) && tx_fire) begin
                sent_i <= sent_i + CW'(1);
            end
            if (root_drop) begin
                own_r <= msg_tbl[int'(k_r)*DATA_W +: DATA_W];
            end
            if (rx_fire) begin
                rcnt <= rcnt + CW'(1);
            end
            if (keep_now) begin
                own_r <= rx_data;
                kept  <= 1'b1;
            end
            if ((state == ST_RELAY) && tx_fire) begin
                relay_sent <= relay_sent + CW'(1);
            end
        end
    end

    AST_FWD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RELAY) && tx_fire) |-> (relay_sent < fwd_r)); // R4
    AST_FWD_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !is_root) |-> (relay_sent == fwd_r)); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rx_ready && !tx_valid)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state == ST_RELAY)) |=> (state != ST_SETUP)); // R10
    AST_ROOT_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROOT_TX) |-> !rx_ready); // R11
endmodule

// File: tb/test_ring_scatter_node.sv
module test_ring_scatter_node;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 8;
    localparam int DW = 16;
    localparam int QN = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      root_idx = '0;
    logic [3:0]      ring_size = 4'd2;
    logic [MAXN*DW-1:0] msg_tbl = '0;
    logic            rx_valid = 1'b0;
    logic [DW-1:0]   rx_data = '0;
    logic            rx_ready;
    logic            tx_valid;
    logic [DW-1:0]   tx_data;
    logic            tx_ready = 1'b0;
    logic [DW-1:0]   own_msg;
    logic            done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_scatter_node #(.MAX_NODES(MAXN), .DATA_W(DW), .NODE_IDX(QN)) i_ring_scatter_node (
        .clk(clk), .rst_n(rst_n), .start(start), .root_idx(root_idx),
        .ring_size(ring_size), .msg_tbl(msg_tbl), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .own_msg(own_msg), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // txm: 0 ready always, 1 ready two of three cycles, 2 ready from cycle 20
    // rxm: 0 offer every cycle, 1 offer every other cycle
    task automatic run_case(input int k, input int p, input int txm, input int rxm,
                            input bit poke, input string tag);
        logic [DW-1:0] exp_tx[$];
        logic [DW-1:0] got[$];
        logic [DW-1:0] src[$];
        logic [DW-1:0] exp_own;
        bit root;
        int fwd;
        int cyc = 0;
        int acc = 0;
        int si = 0;
        int stalls = 0;
        int acc20 = -1;
        bit rfired = 1'b0;
        bit fin = 1'b0;
        bit late_rdy = 1'b0;
        bit hung = 1'b0;
        logic pv = 1'b0;
        logic pr = 1'b0;
        logic [DW-1:0] pd = '0;

        root = (k == QN);
        if (root) begin
            for (int j = 0; j < MAXN; j++) msg_tbl[j*DW +: DW] = DW'(16'h5000 + k*256 + j*17);
            for (int i = 1; i < p; i++) exp_tx.push_back(msg_tbl[((k + p - i) % p)*DW +: DW]);
            exp_own = msg_tbl[k*DW +: DW];
            fwd = 0;
            for (int n = 0; n < 3; n++) src.push_back(DW'(16'hEE00 + n));
        end else begin
            fwd = (((k - 1 - QN) % p) + p) % p;
            for (int n = 0; n < fwd + 3; n++) src.push_back(DW'(16'hA000 + k*256 + p*16 + n));
            for (int n = 0; n < fwd; n++) exp_tx.push_back(src[n]);
            exp_own = src[fwd];
        end

        while (!fin) begin
            @(negedge clk);
            if (rfired) begin si++; acc++; end
            if (pv && !pr) begin
                chk(tx_valid === 1'b1 && tx_data === pd, "R7", {tag, " stalled word held"},
                    longint'(tx_data), longint'(pd));
            end
            if (cyc == 20) acc20 = acc;
            if (done && cyc >= 2) begin
                fin = 1'b1;
            end else begin
                start = (cyc == 0) || (poke && cyc == 6);
                if (poke && cyc == 6) begin
                    root_idx = 3'(QN);
                    ring_size = 4'd3;
                end else begin
                    root_idx = 3'(k);
                    ring_size = 4'(p);
                end
                rx_valid = (si < src.size()) && (rxm == 0 || (cyc % 2) == 0);
                rx_data = rx_valid ? src[si] : '0;
                tx_ready = (txm == 0) ? 1'b1 : (txm == 1) ? ((cyc % 3) != 0) : (cyc >= 20);
                #1;
                rfired = rx_valid && rx_ready;
                if (tx_valid && tx_ready) got.push_back(tx_data);
                if (!root && acc >= fwd + 1 && rx_ready) late_rdy = 1'b1;
                if (txm == 0 && rxm == 0 && !root && acc >= 1 && acc < fwd + 1 &&
                    rx_valid && !rx_ready) stalls++;
                pv = tx_valid; pr = tx_ready; pd = tx_data;
            end
            cyc++;
            if (cyc > 600) begin fin = 1'b1; hung = 1'b1; end
        end
        start = 1'b0;
        rx_valid = 1'b0;
        root_idx = 3'(k);
        ring_size = 4'(p);

        chk(!hung, "R10", {tag, " done reached"}, longint'(hung), 0);
        if (root) begin
            chk(got.size() == exp_tx.size(), "R2", {tag, " root send count"},
                longint'(got.size()), longint'(exp_tx.size()));
            for (int i = 0; i < exp_tx.size() && i < got.size(); i++)
                chk(got[i] === exp_tx[i], "R2", {tag, " root send order"},
                    longint'(got[i]), longint'(exp_tx[i]));
            chk(own_msg === exp_own, "R3", {tag, " root keeps own entry"},
                longint'(own_msg), longint'(exp_own));
            chk(acc == 0, "R11", {tag, " root accepts nothing"}, longint'(acc), 0);
        end else begin
            chk(got.size() == exp_tx.size(), (fwd == 0) ? "R6" : "R4",
                {tag, " forward count"}, longint'(got.size()), longint'(exp_tx.size()));
            for (int i = 0; i < exp_tx.size() && i < got.size(); i++)
                chk(got[i] === exp_tx[i], "R4", {tag, " forwarded word"},
                    longint'(got[i]), longint'(exp_tx[i]));
            chk(own_msg === exp_own, (fwd == 0) ? "R6" : "R5", {tag, " kept word"},
                longint'(own_msg), longint'(exp_own));
            chk(acc == fwd + 1, "R5", {tag, " arrivals accepted"}, longint'(acc), longint'(fwd + 1));
            chk(!late_rdy, "R5", {tag, " ready after keep"}, longint'(late_rdy), 0);
            if (txm == 0 && rxm == 0)
                chk(stalls == 0, "R9", {tag, " stall cycles while streaming"}, longint'(stalls), 0);
            if (txm == 2 && fwd >= 2)
                chk(acc20 == 2, "R8", {tag, " words accepted under stall"}, longint'(acc20), 2);
        end
        for (int c = 0; c < 3; c++) begin
            chk(done === 1'b1 && tx_valid === 1'b0 && rx_ready === 1'b0, "R10",
                {tag, " done holds quiet"}, longint'({done, tx_valid, rx_ready}), 3'b100);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_valid === 1'b0 && rx_ready === 1'b0 && done === 1'b0, "R1", "reset outputs",
            longint'({tx_valid, rx_ready, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid === 1'b0 && rx_ready === 1'b0 && done === 1'b0, "R1", "idle outputs",
            longint'({tx_valid, rx_ready, done}), 0);

        run_case(4, 6, 0, 0, 1'b0, "k4p6 stream");       // R4 R5 R9
        run_case(1, 6, 1, 0, 1'b0, "root p6");           // R2 R3 R11
        run_case(2, 6, 0, 1, 1'b0, "upstream p6");       // R6
        run_case(0, 8, 2, 0, 1'b1, "k0p8 stall poke");   // R8 R10
        run_case(0, 8, 1, 1, 1'b0, "k0p8 gaps");         // R7
        run_case(1, 2, 0, 0, 1'b0, "root p2");           // R2
        run_case(0, 2, 1, 0, 1'b0, "upstream p2");       // R6
        run_case(3, 4, 0, 0, 1'b0, "restart k3p4");      // R12 new k and p after done
        run_case(1, 8, 2, 0, 1'b0, "root p8 stall");     // R2 R7
        run_case(0, 8, 0, 0, 1'b0, "k0p8 stream");       // R9

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule